// File: doc/BRIEF.md
# Latency-Pipelined Register Slave

This block is a small word-addressed register store that sits behind a pipelined request/acknowledge bus. A master opens a bus cycle with the cycle-valid line, offers requests with the strobe line, and each request carries a direction bit, a word address, write data and per-byte lane enables. The slave may hold a request off with its stall output for a configurable number of clocks. Once a request is accepted, its response is returned a fixed number of clocks later, in acceptance order: an acknowledge with read data for an implemented address, or an error for an address beyond the implemented depth.

Responses travel through an in-flight pipeline that is flushed whenever the master lowers the cycle-valid line. A master that abandons a cycle therefore never sees a stale response in a later cycle. The stall length per request comes from a configuration input and is capped by a parameter, so the slave never stalls a strobe for an unbounded time.

Top module: `pbus_lat_slave`

## Requirements
- R1: The acknowledge and error outputs are never high on the same clock.
- R2: While the cycle-valid input is low, acknowledge and error are low; requests accepted before the cycle-valid input fell produce no response, even after it rises again.
- R3: Each accepted request (cycle-valid, strobe high and stall low at a clock edge) yields exactly one response, LATENCY clocks after that edge (default 2), in acceptance order; with LATENCY of at least one, no response is seen when nothing is outstanding.
- R4: Each request is stalled for exactly min(cfg, MAX_STALL-1) consecutive clocks before acceptance (MAX_STALL default 4, so a configuration of 7 stalls 3 clocks); stall and strobe are never high together for MAX_STALL consecutive clocks.
- R5: A word address not below DEPTH (default 40, address width 6) is answered with error instead of acknowledge, and a write to such an address changes no stored word (address 40 does not alias onto address 8).
- R6: A write changes only the byte lanes whose enable bit is set; lane b (bit b of the enable) covers data bits 8b+7 down to 8b; an all-zero enable changes nothing.
- R7: The read-data output carries the word the addressed location held at acceptance on the acknowledge clock, and keeps its last returned value on every clock without an acknowledge.
- R8: During and after reset, acknowledge, error and stall are low and every stored word reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cyc_i | input | 1 | Bus cycle valid |
| stb_i | input | 1 | Request strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| adr_i | input | ADDR_W | Word address |
| dat_i | input | DATA_W | Write data |
| sel_i | input | DATA_W/8 | Byte lane enables |
| stall_cfg_i | input | CFG_W | Requested stall clocks per request |
| stall_o | output | 1 | Request held off |
| ack_o | output | 1 | Successful response |
| err_o | output | 1 | Error response |
| dat_o | output | DATA_W | Read data |

## Verification
A vector table drives single requests one at a time, rotating the stall configuration, so each entry separates stall length, response latency, the ack/error choice and the returned data from each other; full-lane, partial-lane and empty-lane writes followed by reads tell byte-lane masking apart from whole-word writes. Writes and reads at the last implemented address, just past it and at the top of the address space separate a correct range test from aliasing. A back-to-back burst with no stall shows that responses keep order and one-clock spacing, and an abandoned cycle shows that the pipeline flush drops a response that would otherwise appear after cycle-valid returns.

// File: rtl/pbus_lat_pkg.sv
package pbus_lat_pkg;
  typedef enum logic [1:0] {
    RSP_NONE  = 2'd0,
    RSP_OKAY  = 2'd1,
    RSP_FAULT = 2'd2
  } rsp_kind_e;
endpackage

// File: rtl/pbus_lat_stall.sv
module pbus_lat_stall #(
  parameter int CFG_W     = 3,
  parameter int MAX_STALL = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_i,
  input  logic             stb_i,
  input  logic [CFG_W-1:0] cfg_i,
  output logic             stall_o,
  output logic             accept_o
);
  localparam logic [CFG_W-1:0] CAP = CFG_W'(MAX_STALL - 1);

  logic [CFG_W-1:0] wait_q, wait_d, limit;
  logic             req;

  assign req = cyc_i & stb_i;

  always_comb begin
    limit = (cfg_i > CAP) ? CAP : cfg_i;
  end

  assign stall_o  = req & (wait_q < limit);
  assign accept_o = req & ~stall_o;

  always_comb begin
    if (req && stall_o) wait_d = wait_q + 1'b1;
    else                wait_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wait_q <= '0;
    else        wait_q <= wait_d;
  end
endmodule

// File: rtl/pbus_lat_regs.sv
module pbus_lat_regs #(
  parameter int DEPTH  = 40,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en_i,
  input  logic [ADDR_W-1:0]     adr_i,
  input  logic [DATA_W/8-1:0]   sel_i,
  input  logic [DATA_W-1:0]     wdat_i,
  output logic [DATA_W-1:0]     rdat_o,
  output logic                  in_range_o
);
  localparam int NB = DATA_W / 8;

  logic [DATA_W-1:0] words [DEPTH];

  assign in_range_o = ({1'b0, adr_i} < (ADDR_W+1)'(DEPTH));

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    logic [DATA_W-1:0] word_q, word_d;
    logic              hit;

    assign hit = wr_en_i && (adr_i == ADDR_W'(w));

    always_comb begin
      word_d = word_q;
      for (int b = 0; b < NB; b++) begin
        if (hit && sel_i[b]) word_d[b*8 +: 8] = wdat_i[b*8 +: 8];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   word_q <= '0;
      else if (hit) word_q <= word_d;
    end

    assign words[w] = word_q;
  end

  always_comb begin
    rdat_o = '0;
    for (int w = 0; w < DEPTH; w++) begin
      if (adr_i == ADDR_W'(w)) rdat_o = words[w];
    end
  end
endmodule

// File: rtl/pbus_lat_pipe.sv
module pbus_lat_pipe
  import pbus_lat_pkg::*;
#(
  parameter int LATENCY = 2,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_i,
  input  logic              push_i,
  input  logic              fault_i,
  input  logic [DATA_W-1:0] pdat_i,
  output logic              ack_o,
  output logic              err_o,
  output logic [DATA_W-1:0] rdat_o
);
  if (LATENCY == 0) begin : g_direct
    assign ack_o  = cyc_i & push_i & ~fault_i;
    assign err_o  = cyc_i & push_i &  fault_i;
    assign rdat_o = pdat_i;
  end else begin : g_stages
    rsp_kind_e         kind_q [LATENCY];
    rsp_kind_e         kind_d [LATENCY];
    logic [DATA_W-1:0] data_q [LATENCY];
    logic [DATA_W-1:0] data_d [LATENCY];

    always_comb begin
      if (!cyc_i || !push_i) kind_d[0] = RSP_NONE;
      else if (fault_i)      kind_d[0] = RSP_FAULT;
      else                   kind_d[0] = RSP_OKAY;
      data_d[0] = pdat_i;
      for (int i = 1; i < LATENCY; i++) begin
        kind_d[i] = cyc_i ? kind_q[i-1] : RSP_NONE;
        data_d[i] = data_q[i-1];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < LATENCY; i++) begin
          kind_q[i] <= RSP_NONE;
          data_q[i] <= '0;
        end
      end else begin
        for (int i = 0; i < LATENCY; i++) begin
          kind_q[i] <= kind_d[i];
          if (kind_d[i] != RSP_NONE) data_q[i] <= data_d[i];
        end
      end
    end

    assign ack_o  = cyc_i && (kind_q[LATENCY-1] == RSP_OKAY);
    assign err_o  = cyc_i && (kind_q[LATENCY-1] == RSP_FAULT);
    assign rdat_o = data_q[LATENCY-1];
  end
endmodule

// File: rtl/pbus_lat_slave.sv
module pbus_lat_slave #(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 32,
  parameter int DEPTH     = 40,
  parameter int LATENCY   = 2,
  parameter int MAX_STALL = 4,
  parameter int CFG_W     = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cyc_i,
  input  logic                stb_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   adr_i,
  input  logic [DATA_W-1:0]   dat_i,
  input  logic [DATA_W/8-1:0] sel_i,
  input  logic [CFG_W-1:0]    stall_cfg_i,
  output logic                stall_o,
  output logic                ack_o,
  output logic                err_o,
  output logic [DATA_W-1:0]   dat_o
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              accept, in_range, wr_en;
  logic [DATA_W-1:0] rd_word, rsp_dat, hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  pbus_lat_stall #(.CFG_W(CFG_W), .MAX_STALL(MAX_STALL)) u_stall (
    .clk(clk), .rst_n(rst_int_n), .cyc_i(cyc_i), .stb_i(stb_i),
    .cfg_i(stall_cfg_i), .stall_o(stall_o), .accept_o(accept)
  );

  assign wr_en = accept & we_i & in_range;

  pbus_lat_regs #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .wr_en_i(wr_en), .adr_i(adr_i),
    .sel_i(sel_i), .wdat_i(dat_i), .rdat_o(rd_word), .in_range_o(in_range)
  );

  pbus_lat_pipe #(.LATENCY(LATENCY), .DATA_W(DATA_W)) u_pipe (
    .clk(clk), .rst_n(rst_int_n), .cyc_i(cyc_i), .push_i(accept),
    .fault_i(~in_range), .pdat_i(rd_word),
    .ack_o(ack_o), .err_o(err_o), .rdat_o(rsp_dat)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  hold_q <= '0;
    else if (ack_o)  hold_q <= rsp_dat;
  end

  assign dat_o = ack_o ? rsp_dat : hold_q;
endmodule

// File: rtl/pbus_lat_slave_chk.sv
module pbus_lat_slave_chk #(
  parameter int LATENCY   = 2,
  parameter int MAX_STALL = 4
) (
  input logic clk,
  input logic rst_n,
  input logic cyc_i,
  input logic stb_i,
  input logic stall_o,
  input logic ack_o,
  input logic err_o
);
  localparam logic [15:0] STALL_LIM = 16'(MAX_STALL - 1);
  localparam logic [15:0] WAIT_LIM  = 16'(LATENCY);

  logic       acc, rsp;
  logic [7:0]  outst_q;
  logic [15:0] run_q, wait_q;

  assign acc = cyc_i & stb_i & ~stall_o;
  assign rsp = ack_o | err_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outst_q <= '0;
      run_q   <= '0;
      wait_q  <= '0;
    end else begin
      if (!cyc_i) outst_q <= '0;
      else        outst_q <= outst_q + {7'd0, acc} - {7'd0, rsp};
      if (cyc_i && stb_i && stall_o) run_q <= run_q + 16'd1;
      else                           run_q <= '0;
      if (cyc_i && outst_q != 0 && !rsp && !acc) wait_q <= wait_q + 16'd1;
      else                                        wait_q <= '0;
    end
  end

  AST_ACK_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack_o && err_o)); // R1

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_i |-> !ack_o && !err_o); // R2

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (outst_q == 0 && !acc) |-> !rsp); // R3

  AST_STALL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_i && stb_i && stall_o) |-> (run_q < STALL_LIM)); // R4

  AST_ACK_DEADLINE: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_i && outst_q != 0 && !rsp) |-> (wait_q < WAIT_LIM)); // R3

  if (LATENCY > 0) begin : g_min_one
    AST_NO_SAME_CLK: assert property (@(posedge clk) disable iff (!rst_n)
      (outst_q == 0) |-> !rsp); // R3
  end
endmodule

bind pbus_lat_slave pbus_lat_slave_chk #(.LATENCY(LATENCY), .MAX_STALL(MAX_STALL)) chk_i (
  .clk(clk), .rst_n(rst_n), .cyc_i(cyc_i), .stb_i(stb_i),
  .stall_o(stall_o), .ack_o(ack_o), .err_o(err_o)
);

// File: tb/pbus_lat_slave_tb_top.sv
module pbus_lat_slave_tb_top;
  localparam int AW = 6, DW = 32, DEPTH = 40, LAT = 2, MAXST = 4, CW = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cyc, stb, we;
  logic [AW-1:0] adr;
  logic [DW-1:0] wdat;
  logic [3:0]    sel;
  logic [CW-1:0] cfg;
  logic          stall, ack, err;
  logic [DW-1:0] rdat;

  int n_chk = 0;
  int n_err = 0;
  logic [DW-1:0] model [DEPTH];

  always #2 clk = ~clk;

  pbus_lat_slave #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DEPTH), .LATENCY(LAT),
                   .MAX_STALL(MAXST), .CFG_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cyc_i(cyc), .stb_i(stb), .we_i(we),
    .adr_i(adr), .dat_i(wdat), .sel_i(sel), .stall_cfg_i(cfg),
    .stall_o(stall), .ack_o(ack), .err_o(err), .dat_o(rdat)
  );

  // {exp_err, we, adr, sel, data}
  localparam logic [43:0] VEC [12] = '{
    {1'b0, 1'b1, 6'd0,  4'hF,    32'h11223344},
    {1'b0, 1'b1, 6'd5,  4'hF,    32'hAABBCCDD},
    {1'b0, 1'b1, 6'd5,  4'b0101, 32'h01020304},
    {1'b0, 1'b0, 6'd5,  4'hF,    32'h00000000},
    {1'b0, 1'b1, 6'd8,  4'hF,    32'hCAFEF00D},
    {1'b1, 1'b1, 6'd40, 4'hF,    32'hDEADBEEF},
    {1'b0, 1'b0, 6'd8,  4'hF,    32'h00000000},
    {1'b0, 1'b1, 6'd39, 4'b1000, 32'h7F000000},
    {1'b0, 1'b0, 6'd39, 4'hF,    32'h00000000},
    {1'b1, 1'b0, 6'd63, 4'hF,    32'h00000000},
    {1'b0, 1'b1, 6'd0,  4'b0000, 32'hFFFFFFFF},
    {1'b0, 1'b0, 6'd0,  4'hF,    32'h00000000}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_req(input logic w, input logic [AW-1:0] a, input logic [3:0] s,
                         input logic [31:0] d, input logic [CW-1:0] c,
                         output logic g_ack, output logic g_err, output logic [31:0] g_dat,
                         output int nst, output int nlat, output logic extra, output logic [31:0] held);
    @(negedge clk);
    cyc = 1'b1; stb = 1'b1; we = w; adr = a; sel = s; wdat = d; cfg = c;
    #1;
    nst = 0;
    while (stall && nst < 20) begin
      nst++;
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    stb = 1'b0; we = 1'b0;
    #1;
    nlat = 1;
    while (!ack && !err && nlat < 20) begin
      @(negedge clk);
      #1;
      nlat++;
    end
    g_ack = ack; g_err = err; g_dat = rdat;
    @(negedge clk);
    #1;
    extra = ack | err;
    held  = rdat;
    @(negedge clk);
    cyc = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 20000, 0);
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin : main
    logic g_ack, g_err, extra;
    logic [31:0] g_dat, held, expd;
    int nst, nlat;

    rst_n = 1'b0; cyc = 0; stb = 0; we = 0; adr = '0; wdat = '0; sel = '0; cfg = '0;
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    #1;
    chk(!ack && !err && !stall, "R8 reset outputs", {29'd0, ack, err, stall}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    run_req(1'b0, 6'd3, 4'hF, 32'd0, 3'd0, g_ack, g_err, g_dat, nst, nlat, extra, held);
    chk(g_ack && g_dat == 32'd0, "R8 word reads zero after reset", g_dat, 32'd0);

    // table walk
    for (int i = 0; i < 12; i++) begin
      logic e_err, v_we;
      logic [AW-1:0] v_adr;
      logic [3:0] v_sel;
      logic [31:0] v_dat;
      logic [CW-1:0] c;
      {e_err, v_we, v_adr, v_sel, v_dat} = VEC[i];
      c = CW'(i % 4);
      expd = (v_adr < AW'(DEPTH)) ? model[v_adr] : 32'd0;
      run_req(v_we, v_adr, v_sel, v_dat, c, g_ack, g_err, g_dat, nst, nlat, extra, held);
      chk(nst == int'(c), "R4 stall clocks", nst, int'(c));
      chk(nlat == LAT, "R3 response latency", nlat, LAT);
      chk(!(g_ack && g_err), "R1 exclusive response", {30'd0, g_ack, g_err}, 32'd0);
      chk(g_err == e_err && g_ack == !e_err, "R5 ack/error choice", {30'd0, g_ack, g_err}, {30'd0, !e_err, e_err});
      chk(!extra, "R3 single response", {31'd0, extra}, 32'd0);
      if (!v_we && !e_err) begin
        chk(g_dat == expd, "R6 R7 read data", g_dat, expd);
        chk(held == g_dat, "R7 read data held", held, g_dat);
      end
      if (v_we && !e_err) begin
        for (int b = 0; b < 4; b++)
          if (v_sel[b]) model[v_adr][b*8 +: 8] = v_dat[b*8 +: 8];
      end
    end

    // R5: out-of-range write to 40 must not alias onto 8
    run_req(1'b0, 6'd8, 4'hF, 32'd0, 3'd0, g_ack, g_err, g_dat, nst, nlat, extra, held);
    chk(g_dat == 32'hCAFEF00D, "R5 no alias write", g_dat, 32'hCAFEF00D);

    // R4: stall configuration above cap saturates at MAX_STALL-1
    run_req(1'b0, 6'd0, 4'hF, 32'd0, 3'd7, g_ack, g_err, g_dat, nst, nlat, extra, held);
    chk(nst == MAXST - 1, "R4 stall cap", nst, MAXST - 1);

    // R3 R7: back-to-back reads, in order
    @(negedge clk); cyc = 1; stb = 1; we = 0; adr = 6'd0; cfg = 3'd0;
    @(negedge clk); adr = 6'd5; #1;
    chk(!ack && !err, "R3 no early response", {30'd0, ack, err}, 32'd0);
    @(negedge clk); adr = 6'd8; #1;
    chk(ack && rdat == model[0], "R3 burst first", rdat, model[0]);
    @(negedge clk); stb = 0; #1;
    chk(ack && rdat == model[5], "R3 burst second", rdat, model[5]);
    @(negedge clk); #1;
    chk(ack && rdat == model[8], "R3 burst third", rdat, model[8]);
    @(negedge clk); #1;
    chk(!ack && rdat == model[8], "R7 hold after burst", rdat, model[8]);
    @(negedge clk); cyc = 0;

    // R2: abandoned cycle flushes in-flight response
    begin
      logic seen;
      seen = 1'b0;
      @(negedge clk); cyc = 1; stb = 1; we = 0; adr = 6'd0; cfg = 3'd0;
      @(negedge clk); cyc = 0; stb = 0;
      for (int k = 0; k < 3; k++) begin
        #1; seen = seen | ack | err;
        @(negedge clk);
      end
      cyc = 1;
      for (int k = 0; k < 4; k++) begin
        #1; seen = seen | ack | err;
        @(negedge clk);
      end
      cyc = 0;
      chk(!seen, "R2 flushed on abort", {31'd0, seen}, 32'd0);
    end

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule